// File: doc/BRIEF.md
# Execute-Stage Operand Forwarding Unit

This block sits in the execute stage of a five-stage, in-order integer pipeline. Its job is to keep dependent instructions from using stale register-file values. It compares the two source register numbers of the instruction now in execute against the destination registers of the two older instructions ahead of it. One older instruction sits in the memory stage and the other in the writeback stage. For each operand, the block drives a two-bit select and the chosen value. The value comes from the register file read, the memory-stage ALU result or the writeback value.

A third, one-bit select covers a store in the memory stage whose data register is the destination of a load now in writeback. In that case the loaded value replaces the store write-data going to data memory.

All selection logic is combinational. The block has no clock and no state. It relies on the register file writing in the first half of a cycle, so a result three instructions back is already visible through the ordinary register read.

Top module: `ex_fwd_unit`

## Requirements
- R1: Each operand select is 2 bits, and the forwarded value follows it: code 0 passes the register-file value, code 1 passes the writeback value, and code 2 passes the memory-stage ALU result.
- R2: Operand A's select is 2 when the memory-stage write flag is 1 and the memory-stage destination equals the execute source `ex_src_a` and is nonzero.
- R3: Operand B's select is 2 when the memory-stage write flag is 1 and the memory-stage destination equals the execute source `ex_src_b` and is nonzero.
- R4: An operand's select is 1 when the writeback write flag is 1, the writeback destination equals that operand's source and is nonzero, and the memory-stage condition of R2/R3 does not hold for that operand.
- R5: When both older instructions write the same nonzero register that an operand reads, the newer one wins: the select is 2 and the value is the memory-stage result.
- R6: Register 0 is never forwarded. A source number of 0 gives select 0 and the register-file value, whatever the destination fields hold.
- R7: With no matching, enabled, nonzero destination, both selects are 0 and both operand outputs equal the register-file values.
- R8: The store-data select is 1 exactly when a store sits in the memory stage, a load with its write flag set sits in writeback, and the load destination is nonzero and equals the store's data register. In that case the store write-data output is the writeback value; otherwise it is the store's own data.
- R9: In a dependent sequence with every register starting at its index plus 100 (sub r2=r1-r3; and r12=r2&r5; or r13=r6|r2; add r14=r2+r2; store r15 at r2+100), every consumer sees r2 = -2. The and takes it from the memory stage (select 2), the or takes it from writeback (select 1), and the add and store take it from the register file (select 0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ex_src_a | input | REG_W | First source register of the instruction in execute |
| ex_src_b | input | REG_W | Second source register of the instruction in execute |
| rf_val_a | input | DATA_W | Register-file value read for operand A |
| rf_val_b | input | DATA_W | Register-file value read for operand B |
| mem_dst | input | REG_W | Destination register of the memory-stage instruction |
| mem_wen | input | 1 | Memory-stage instruction writes a register |
| mem_alu | input | DATA_W | ALU result held in the memory stage |
| wb_dst | input | REG_W | Destination register of the writeback-stage instruction |
| wb_wen | input | 1 | Writeback-stage instruction writes a register |
| wb_is_load | input | 1 | Writeback-stage instruction is a load |
| wb_val | input | DATA_W | Value being written back |
| mem_is_store | input | 1 | Memory-stage instruction is a store |
| mem_st_reg | input | REG_W | Data register of the memory-stage store |
| mem_st_data | input | DATA_W | Store data carried down the pipeline |
| sel_a | output | 2 | Operand A select (0 register file, 1 writeback, 2 memory stage) |
| sel_b | output | 2 | Operand B select, same coding |
| opnd_a | output | DATA_W | Forwarded operand A |
| opnd_b | output | DATA_W | Forwarded operand B |
| sel_st | output | 1 | Store-data forward select |
| st_wdata | output | DATA_W | Store write-data to data memory |

## Verification
The two forwarding paths can match in the same cycle. That happens when both older instructions name the register an operand reads, or when one operand matches the memory stage while the other matches writeback. The vector table places exactly those overlaps, including one where the memory-stage write flag is low. Each case is judged by the select and the delivered value, which must come from the newer match, or from the only enabled one. The store-data path is exercised on its own, and the dependent five-instruction sequence is then replayed cycle by cycle against a bench register-file model.

// File: rtl/ex_fwd_pkg.sv
package ex_fwd_pkg;

    typedef enum logic [1:0] {
        SRC_RF   = 2'd0,
        SRC_WB   = 2'd1,
        SRC_MEM  = 2'd2,
        SRC_RSVD = 2'd3
    } fwd_src_e;

    localparam int N_OPND = 2;

endpackage

// File: rtl/ex_fwd_match.sv
module ex_fwd_match #(
    parameter int REG_W = 5
) (
    input  logic [REG_W-1:0] src,
    input  logic [REG_W-1:0] mem_dst,
    input  logic             mem_wen,
    input  logic [REG_W-1:0] wb_dst,
    input  logic             wb_wen,
    output logic [1:0]       sel
);
    import ex_fwd_pkg::*;

    localparam logic [REG_W-1:0] ZERO_REG = '0;

    logic hit_mem;
    logic hit_wb;

    always_comb begin
        hit_mem = mem_wen && (mem_dst != ZERO_REG) && (mem_dst == src);
        hit_wb  = wb_wen  && (wb_dst  != ZERO_REG) && (wb_dst  == src);
    end

    always_comb begin
        sel = SRC_RF;
        if (hit_mem) begin
            sel = SRC_MEM;
        end else if (hit_wb) begin
            sel = SRC_WB;
        end
    end

endmodule

// File: rtl/ex_fwd_opmux.sv
module ex_fwd_opmux #(
    parameter int DATA_W = 32
) (
    input  logic [1:0]        sel,
    input  logic [DATA_W-1:0] rf_val,
    input  logic [DATA_W-1:0] wb_val,
    input  logic [DATA_W-1:0] mem_val,
    output logic [DATA_W-1:0] y
);
    import ex_fwd_pkg::*;

    always_comb begin
        unique case (fwd_src_e'(sel))
            SRC_WB:   y = wb_val;
            SRC_MEM:  y = mem_val;
            SRC_RF:   y = rf_val;
            SRC_RSVD: y = rf_val;
            default:  y = rf_val;
        endcase
    end

endmodule

// File: rtl/ex_fwd_store.sv
module ex_fwd_store #(
    parameter int REG_W  = 5,
    parameter int DATA_W = 32
) (
    input  logic              mem_is_store,
    input  logic [REG_W-1:0]  mem_st_reg,
    input  logic [DATA_W-1:0] mem_st_data,
    input  logic              wb_is_load,
    input  logic              wb_wen,
    input  logic [REG_W-1:0]  wb_dst,
    input  logic [DATA_W-1:0] wb_val,
    output logic              sel_st,
    output logic [DATA_W-1:0] st_wdata
);
    localparam logic [REG_W-1:0] ZERO_REG = '0;

    always_comb begin
        sel_st = mem_is_store && wb_is_load && wb_wen
                 && (wb_dst != ZERO_REG) && (wb_dst == mem_st_reg);
        st_wdata = sel_st ? wb_val : mem_st_data;
    end

endmodule

// File: rtl/ex_fwd_unit.sv
module ex_fwd_unit #(
    parameter int REG_W  = 5,
    parameter int DATA_W = 32
) (
    input  logic [REG_W-1:0]  ex_src_a,
    input  logic [REG_W-1:0]  ex_src_b,
    input  logic [DATA_W-1:0] rf_val_a,
    input  logic [DATA_W-1:0] rf_val_b,
    input  logic [REG_W-1:0]  mem_dst,
    input  logic              mem_wen,
    input  logic [DATA_W-1:0] mem_alu,
    input  logic [REG_W-1:0]  wb_dst,
    input  logic              wb_wen,
    input  logic              wb_is_load,
    input  logic [DATA_W-1:0] wb_val,
    input  logic              mem_is_store,
    input  logic [REG_W-1:0]  mem_st_reg,
    input  logic [DATA_W-1:0] mem_st_data,
    output logic [1:0]        sel_a,
    output logic [1:0]        sel_b,
    output logic [DATA_W-1:0] opnd_a,
    output logic [DATA_W-1:0] opnd_b,
    output logic              sel_st,
    output logic [DATA_W-1:0] st_wdata
);
    import ex_fwd_pkg::*;

    logic [REG_W-1:0]  src_v [N_OPND];
    logic [DATA_W-1:0] rf_v  [N_OPND];
    logic [1:0]        sel_v [N_OPND];
    logic [DATA_W-1:0] out_v [N_OPND];

    always_comb begin
        src_v[0] = ex_src_a;
        src_v[1] = ex_src_b;
        rf_v[0]  = rf_val_a;
        rf_v[1]  = rf_val_b;
    end

    for (genvar g = 0; g < N_OPND; g++) begin : g_opnd
        ex_fwd_match #(.REG_W(REG_W)) u_match (
            .src     (src_v[g]),
            .mem_dst (mem_dst),
            .mem_wen (mem_wen),
            .wb_dst  (wb_dst),
            .wb_wen  (wb_wen),
            .sel     (sel_v[g])
        );

        ex_fwd_opmux #(.DATA_W(DATA_W)) u_mux (
            .sel     (sel_v[g]),
            .rf_val  (rf_v[g]),
            .wb_val  (wb_val),
            .mem_val (mem_alu),
            .y       (out_v[g])
        );
    end

    ex_fwd_store #(.REG_W(REG_W), .DATA_W(DATA_W)) u_store (
        .mem_is_store (mem_is_store),
        .mem_st_reg   (mem_st_reg),
        .mem_st_data  (mem_st_data),
        .wb_is_load   (wb_is_load),
        .wb_wen       (wb_wen),
        .wb_dst       (wb_dst),
        .wb_val       (wb_val),
        .sel_st       (sel_st),
        .st_wdata     (st_wdata)
    );

    always_comb begin
        sel_a  = sel_v[0];
        sel_b  = sel_v[1];
        opnd_a = out_v[0];
        opnd_b = out_v[1];
    end

endmodule

// File: rtl/ex_fwd_unit_chk.sv
module ex_fwd_unit_chk #(
    parameter int REG_W  = 5,
    parameter int DATA_W = 32
) (
    input logic [REG_W-1:0]  ex_src_a,
    input logic [REG_W-1:0]  ex_src_b,
    input logic [DATA_W-1:0] rf_val_a,
    input logic [REG_W-1:0]  mem_dst,
    input logic              mem_wen,
    input logic [DATA_W-1:0] mem_alu,
    input logic [REG_W-1:0]  wb_dst,
    input logic              wb_wen,
    input logic [DATA_W-1:0] wb_val,
    input logic [1:0]        sel_a,
    input logic [1:0]        sel_b,
    input logic [DATA_W-1:0] opnd_a,
    input logic [DATA_W-1:0] opnd_b,
    input logic              sel_st,
    input logic [DATA_W-1:0] st_wdata
);
    localparam logic [REG_W-1:0] Z = '0;

    always_comb begin
        if (mem_wen && mem_dst != Z && mem_dst == ex_src_a)
            assert_mem_pick_a_R2: assert (sel_a == 2'd2 && opnd_a == mem_alu);
        if (mem_wen && mem_dst != Z && mem_dst == ex_src_b)
            assert_mem_pick_b_R3: assert (sel_b == 2'd2 && opnd_b == mem_alu);
        if (wb_wen && wb_dst != Z && wb_dst == ex_src_a
            && !(mem_wen && mem_dst == ex_src_a))
            assert_wb_pick_a_R4: assert (sel_a == 2'd1 && opnd_a == wb_val);
        if (ex_src_a == Z)
            assert_zero_src_R6: assert (sel_a == 2'd0 && opnd_a == rf_val_a);
        assert_no_rsvd_code_R1: assert (sel_a != 2'd3 && sel_b != 2'd3);
        if (sel_st)
            assert_store_fwd_R8: assert (st_wdata == wb_val);
    end

endmodule

bind ex_fwd_unit ex_fwd_unit_chk #(.REG_W(REG_W), .DATA_W(DATA_W)) u_chk (
    .ex_src_a (ex_src_a),
    .ex_src_b (ex_src_b),
    .rf_val_a (rf_val_a),
    .mem_dst  (mem_dst),
    .mem_wen  (mem_wen),
    .mem_alu  (mem_alu),
    .wb_dst   (wb_dst),
    .wb_wen   (wb_wen),
    .wb_val   (wb_val),
    .sel_a    (sel_a),
    .sel_b    (sel_b),
    .opnd_a   (opnd_a),
    .opnd_b   (opnd_b),
    .sel_st   (sel_st),
    .st_wdata (st_wdata)
);

// File: tb/ex_fwd_unit_bench.sv
module ex_fwd_unit_bench;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic [4:0]  ex_src_a, ex_src_b, mem_dst, wb_dst, mem_st_reg;
    logic [31:0] rf_val_a, rf_val_b, mem_alu, wb_val, mem_st_data;
    logic        mem_wen, wb_wen, wb_is_load, mem_is_store;
    logic [1:0]  sel_a, sel_b;
    logic [31:0] opnd_a, opnd_b, st_wdata;
    logic        sel_st;

    ex_fwd_unit u_ex_fwd_unit (
        .ex_src_a(ex_src_a), .ex_src_b(ex_src_b),
        .rf_val_a(rf_val_a), .rf_val_b(rf_val_b),
        .mem_dst(mem_dst), .mem_wen(mem_wen), .mem_alu(mem_alu),
        .wb_dst(wb_dst), .wb_wen(wb_wen), .wb_is_load(wb_is_load), .wb_val(wb_val),
        .mem_is_store(mem_is_store), .mem_st_reg(mem_st_reg), .mem_st_data(mem_st_data),
        .sel_a(sel_a), .sel_b(sel_b), .opnd_a(opnd_a), .opnd_b(opnd_b),
        .sel_st(sel_st), .st_wdata(st_wdata)
    );

    int n_run  = 0;
    int n_fail = 0;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // R1 coding: 0 register file, 1 writeback, 2 memory stage
    function automatic logic [31:0] pick(input logic [1:0] s, input logic [31:0] rf);
        case (s)
            2'd1:    return 32'hF0F0_0001;
            2'd2:    return 32'hE0E0_0002;
            default: return rf;
        endcase
    endfunction

    typedef struct packed {
        logic [4:0] rs;
        logic [4:0] rt;
        logic [4:0] mrd;
        logic       mwe;
        logic [4:0] wrd;
        logic       wwe;
        logic [1:0] ea;
        logic [1:0] eb;
    } vec_t;

    localparam int NV = 9;
    localparam vec_t VECS [NV] = '{
        '{5'd1,  5'd2,  5'd1,  1'b1, 5'd9,  1'b1, 2'd2, 2'd0},  // R2
        '{5'd3,  5'd4,  5'd4,  1'b1, 5'd3,  1'b1, 2'd1, 2'd2},  // R3 R4 same cycle
        '{5'd5,  5'd5,  5'd5,  1'b1, 5'd5,  1'b1, 2'd2, 2'd2},  // R5 newer wins
        '{5'd6,  5'd7,  5'd8,  1'b1, 5'd7,  1'b1, 2'd0, 2'd1},  // R4
        '{5'd0,  5'd0,  5'd0,  1'b1, 5'd0,  1'b1, 2'd0, 2'd0},  // R6
        '{5'd9,  5'd9,  5'd9,  1'b0, 5'd9,  1'b0, 2'd0, 2'd0},  // R7 flags low
        '{5'd10, 5'd11, 5'd12, 1'b1, 5'd13, 1'b1, 2'd0, 2'd0},  // R7 no match
        '{5'd14, 5'd15, 5'd14, 1'b0, 5'd14, 1'b1, 2'd1, 2'd0},  // R4 mem flag low
        '{5'd0,  5'd3,  5'd0,  1'b1, 5'd3,  1'b1, 2'd0, 2'd1}   // R6 with R4
    };

    // pipeline model for R9
    logic [31:0] regs [32];
    logic [31:0] res  [5];
    logic [4:0]  i_rs [5];
    logic [4:0]  i_rt [5];
    logic [4:0]  i_rd [5];
    logic        i_we [5];

    initial begin
        #(200000 * 10);
        n_run++;
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        ex_src_a = '0; ex_src_b = '0; mem_dst = '0; wb_dst = '0; mem_st_reg = '0;
        rf_val_a = 32'hAAAA_0000; rf_val_b = 32'hBBBB_0000;
        mem_alu = 32'hE0E0_0002; wb_val = 32'hF0F0_0001; mem_st_data = 32'h5757_0000;
        mem_wen = 0; wb_wen = 0; wb_is_load = 0; mem_is_store = 0;
        @(negedge clk); #1;
        // idle state: everything passes through (R7, R8)
        chk("R7 idle sel_a", {30'd0, sel_a}, 32'd0);
        chk("R7 idle opnd_b", opnd_b, 32'hBBBB_0000);
        chk("R8 idle sel_st", {31'd0, sel_st}, 32'd0);
        chk("R8 idle st_wdata", st_wdata, 32'h5757_0000);

        for (int v = 0; v < NV; v++) begin
            @(negedge clk);
            ex_src_a = VECS[v].rs;  ex_src_b = VECS[v].rt;
            mem_dst = VECS[v].mrd;  mem_wen = VECS[v].mwe;
            wb_dst = VECS[v].wrd;   wb_wen = VECS[v].wwe;
            #1;
            chk($sformatf("R1-vec%0d sel_a", v), {30'd0, sel_a}, {30'd0, VECS[v].ea});
            chk($sformatf("R1-vec%0d sel_b", v), {30'd0, sel_b}, {30'd0, VECS[v].eb});
            chk($sformatf("R1-vec%0d opnd_a", v), opnd_a, pick(VECS[v].ea, 32'hAAAA_0000));
            chk($sformatf("R1-vec%0d opnd_b", v), opnd_b, pick(VECS[v].eb, 32'hBBBB_0000));
        end

        // store-data forwarding, R8 positive and R8 negative corners
        @(negedge clk);
        ex_src_a = '0; ex_src_b = '0; mem_wen = 0;
        mem_is_store = 1; wb_is_load = 1; wb_wen = 1; wb_dst = 5'd4; mem_st_reg = 5'd4;
        #1;
        chk("R8 load->store sel_st", {31'd0, sel_st}, 32'd1);
        chk("R8 load->store data", st_wdata, 32'hF0F0_0001);
        wb_dst = 5'd0; mem_st_reg = 5'd0; #1;
        chk("R8 zero reg data", st_wdata, 32'h5757_0000);
        wb_dst = 5'd4; mem_st_reg = 5'd4; wb_is_load = 0; #1;
        chk("R8 not load data", st_wdata, 32'h5757_0000);
        wb_is_load = 1; wb_wen = 0; #1;
        chk("R8 write off data", st_wdata, 32'h5757_0000);
        wb_wen = 1; mem_is_store = 0; #1;
        chk("R8 not store sel_st", {31'd0, sel_st}, 32'd0);
        mem_is_store = 1; mem_st_reg = 5'd5; #1;
        chk("R8 reg mismatch data", st_wdata, 32'h5757_0000);
        mem_is_store = 0; wb_is_load = 0;

        // R9 dependent sequence
        for (int r = 0; r < 32; r++) regs[r] = (r == 0) ? 32'd0 : 32'(r + 100);
        i_rs = '{5'd1, 5'd2, 5'd6, 5'd2, 5'd2};
        i_rt = '{5'd3, 5'd5, 5'd2, 5'd2, 5'd15};
        i_rd = '{5'd2, 5'd12, 5'd13, 5'd14, 5'd0};
        i_we = '{1'b1, 1'b1, 1'b1, 1'b1, 1'b0};
        for (int e = 0; e < 5; e++) begin
            @(negedge clk);
            // writeback three instructions back is visible through the read
            if (e >= 3 && i_we[e-3]) regs[i_rd[e-3]] = res[e-3];
            ex_src_a = i_rs[e]; ex_src_b = i_rt[e];
            rf_val_a = regs[i_rs[e]]; rf_val_b = regs[i_rt[e]];
            mem_dst = (e >= 1) ? i_rd[e-1] : 5'd0; mem_wen = (e >= 1) ? i_we[e-1] : 1'b0;
            mem_alu = (e >= 1) ? res[e-1] : 32'd0;
            wb_dst  = (e >= 2) ? i_rd[e-2] : 5'd0; wb_wen = (e >= 2) ? i_we[e-2] : 1'b0;
            wb_val  = (e >= 2) ? res[e-2] : 32'd0;
            #1;
            case (e)
                0: res[e] = opnd_a - opnd_b;
                1: res[e] = opnd_a & opnd_b;
                2: res[e] = opnd_a | opnd_b;
                3: res[e] = opnd_a + opnd_b;
                default: res[e] = opnd_a + 32'd100;
            endcase
            case (e)
                0: chk("R9 sub result", res[0], 32'hFFFF_FFFE);
                1: begin
                    chk("R9 and sel_a", {30'd0, sel_a}, 32'd2);
                    chk("R9 and opnd_a", opnd_a, 32'hFFFF_FFFE);
                end
                2: begin
                    chk("R9 or sel_b", {30'd0, sel_b}, 32'd1);
                    chk("R9 or opnd_b", opnd_b, 32'hFFFF_FFFE);
                end
                3: begin
                    chk("R9 add sel_a", {30'd0, sel_a}, 32'd0);
                    chk("R9 add opnd_a", opnd_a, 32'hFFFF_FFFE);
                    chk("R9 add opnd_b", opnd_b, 32'hFFFF_FFFE);
                end
                default: begin
                    chk("R9 store sel_a", {30'd0, sel_a}, 32'd0);
                    chk("R9 store base", opnd_a, 32'hFFFF_FFFE);
                end
            endcase
        end

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule